// File: doc/BRIEF.md
# Parallel NFA State-Transition Array

This block runs a non-deterministic finite automaton over a stream of 8-bit symbols at one symbol per clock. It holds a fixed number of state elements, 32 by default. Each element has a programmable 256-bit symbol-class mask, a start mode, a report flag, and one row of an element-to-element connection matrix. Every element tests the same symbol in the same cycle. An element is allowed to match only when it is enabled. An edge-only element is enabled when at least one upstream element that connects to it matched the previous symbol. A start-of-data element is enabled on the first symbol of a stream. An all-input element is enabled on every symbol.

Software loads masks, modes, report flags and connection rows through a single-cycle write port. It then streams symbols in with a valid qualifier and a start-of-data strobe. The block returns one registered match bit and one registered report bit per element, together with a valid flag. A host combines these vectors into pattern hits.

Top module: `nfa_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `match_o`, `report_o` and `out_valid` at zero. All activations are cleared, and all masks, modes, report flags and connection rows are cleared.
- R2: A symbol accepted with `sym_valid` high produces `out_valid` high on the next cycle. On that cycle, `match_o[e]` is set only if element e was enabled for that symbol and bit `sym` of its mask is set.
- R3: An edge-only element (mode value 0, and value 3 behaves the same way) that no upstream element has activated never matches, even when its mask holds the symbol.
- R4: An element is activated for the next valid symbol when any element with a connection to it matched. Several incoming connections are combined by OR.
- R5: A chain of connections matches a sequence. Element a matching symbol k activates element b, and b then matches symbol k+1.
- R6: A start-of-data element (mode value 1) is enabled only on a symbol presented with `sym_sod` high.
- R7: An all-input element (mode value 2) is enabled on every valid symbol, without needing any activation.
- R8: A connection from an element to itself keeps that element matching for as long as each symbol falls in its mask.
- R9: `report_o[e]` equals `match_o[e]` AND the report flag of element e. It is never set without the match.
- R10: A cycle with `sym_valid` low leaves every activation unchanged and gives zero `match_o` and `report_o` and low `out_valid` on the next cycle.
- R11: A symbol presented with `sym_sod` high ignores all activations left over from earlier symbols.
- R12: Configuration writes take effect from the next cycle, and the value of `cfg_sel` picks the target. With `cfg_sel` = 0, `cfg_data` replaces mask bits for symbols `cfg_word*32` to `cfg_word*32+31`, and bit n stands for symbol `cfg_word*32+n`. With `cfg_sel` = 1, `cfg_data[1:0]` is the mode and `cfg_data[2]` is the report flag. With `cfg_sel` = 2, `cfg_data[j]` creates a connection from element `cfg_elem` to element j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 mask word, 1 mode and report, 2 connection row |
| cfg_elem | input | 5 | Element addressed by the write |
| cfg_word | input | 3 | Mask word index for mask writes |
| cfg_data | input | 32 | Write data |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_sod | input | 1 | Symbol is the first of a new stream |
| sym | input | 8 | Input symbol |
| out_valid | output | 1 | Match and report vectors belong to a symbol |
| match_o | output | 32 | Per-element match result |
| report_o | output | 32 | Per-element report result |

## Verification
Every result comes from one register stage. The match and report vectors for a symbol driven before edge k can be read after edge k. A symbol presented there shifts the activations, and those activations shape the result that appears one edge later. The bench drives each symbol on a falling edge and pushes the expected pair into a queue. A monitor pops that pair and compares it on the next falling edge where `out_valid` is high, so each comparison lands exactly one edge after its stimulus. For idle slots, the bench checks directly on the falling edge after the idle cycle that the outputs are zero. A later symbol then shows whether the activations were held.

// File: rtl/nfa_pkg.sv
// Shared encodings for the NFA state-transition array.
// Assumes no other package defines these names.
package nfa_pkg;
    // Start modes held per element
    localparam logic [1:0] START_EDGE = 2'd0;
    localparam logic [1:0] START_SOD  = 2'd1;
    localparam logic [1:0] START_ALL  = 2'd2;

    // Configuration write targets
    localparam logic [1:0] CFG_MASK = 2'd0;
    localparam logic [1:0] CFG_MODE = 2'd1;
    localparam logic [1:0] CFG_EDGE = 2'd2;
endpackage

// File: rtl/nfa_cfg_store.sv
// Configuration storage: symbol-class masks, start modes, report flags
// and connection rows for every element.
// Assumes N_ELEM <= DATA_W and that DATA_W divides the alphabet size.
module nfa_cfg_store
    import nfa_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int SYM_W  = 8,
    parameter int DATA_W = 32,
    localparam int ALPHA = 1 << SYM_W,
    localparam int WORDS = ALPHA / DATA_W,
    localparam int EW    = $clog2(N_ELEM),
    localparam int WW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [1:0]                      cfg_sel,
    input  logic [EW-1:0]                   cfg_elem,
    input  logic [WW-1:0]                   cfg_word,
    input  logic [DATA_W-1:0]               cfg_data,
    output logic [N_ELEM-1:0][ALPHA-1:0]    mask_o,
    output logic [N_ELEM-1:0][1:0]          mode_o,
    output logic [N_ELEM-1:0]               rep_o,
    output logic [N_ELEM-1:0][N_ELEM-1:0]   edge_o
);
    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        logic hit_e;
        assign hit_e = cfg_we && (cfg_elem == EW'(e));

        // Mask word replacement for this element
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_o[e] <= '0;
            else if (hit_e && cfg_sel == CFG_MASK)
                mask_o[e][cfg_word*DATA_W +: DATA_W] <= cfg_data;
        end

        // Start mode and report flag for this element
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_o[e] <= START_EDGE;
                rep_o[e]  <= 1'b0;
            end else if (hit_e && cfg_sel == CFG_MODE) begin
                mode_o[e] <= cfg_data[1:0];
                rep_o[e]  <= cfg_data[2];
            end
        end

        // Outgoing connection row for this element
        always_ff @(posedge clk) begin
            if (!rst_n)
                edge_o[e] <= '0;
            else if (hit_e && cfg_sel == CFG_EDGE)
                edge_o[e] <= cfg_data[N_ELEM-1:0];
        end
    end
endmodule

// File: rtl/nfa_match_unit.sv
// Per-element enable and symbol test. An element is enabled from its
// activation (ignored on a start-of-data symbol) or from its start mode,
// and it matches when enabled and its mask holds the symbol.
// Purely combinational.
module nfa_match_unit
    import nfa_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int SYM_W  = 8,
    localparam int ALPHA = 1 << SYM_W
) (
    input  logic [N_ELEM-1:0]             act_i,
    input  logic                          sod_i,
    input  logic [SYM_W-1:0]              sym_i,
    input  logic [N_ELEM-1:0][1:0]        mode_i,
    input  logic [N_ELEM-1:0][ALPHA-1:0]  mask_i,
    output logic [N_ELEM-1:0]             hit_o
);
    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        logic en;
        // Enable from activation or start mode
        always_comb begin
            en = (act_i[e] && !sod_i)
               || (mode_i[e] == START_ALL)
               || (mode_i[e] == START_SOD && sod_i);
        end
        assign hit_o[e] = en && mask_i[e][sym_i];
    end
endmodule

// File: rtl/nfa_route.sv
// Connection matrix routing: the next activation of each element is the
// OR of the hits of all elements whose row connects to it.
// Purely combinational.
module nfa_route #(
    parameter int N_ELEM = 32
) (
    input  logic [N_ELEM-1:0]             hit_i,
    input  logic [N_ELEM-1:0][N_ELEM-1:0] edge_i,
    output logic [N_ELEM-1:0]             next_o
);
    // OR-reduce each column of the connection matrix, gated by hits
    always_comb begin
        next_o = '0;
        for (int src = 0; src < N_ELEM; src++) begin
            if (hit_i[src])
                next_o = next_o | edge_i[src];
        end
    end
endmodule

// File: rtl/nfa_array.sv
// Top of the parallel NFA state-transition array. Holds the activation
// register and the registered outputs. Assumes one symbol per clock with
// sym_sod meaningful only when sym_valid is high.
module nfa_array
    import nfa_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int SYM_W  = 8,
    parameter int DATA_W = 32,
    localparam int ALPHA = 1 << SYM_W,
    localparam int WORDS = ALPHA / DATA_W,
    localparam int EW    = $clog2(N_ELEM),
    localparam int WW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [EW-1:0]     cfg_elem,
    input  logic [WW-1:0]     cfg_word,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              sym_valid,
    input  logic              sym_sod,
    input  logic [SYM_W-1:0]  sym,
    output logic              out_valid,
    output logic [N_ELEM-1:0] match_o,
    output logic [N_ELEM-1:0] report_o
);
    logic [N_ELEM-1:0][ALPHA-1:0]  mask_w;
    logic [N_ELEM-1:0][1:0]        mode_w;
    logic [N_ELEM-1:0]             rep_w;
    logic [N_ELEM-1:0][N_ELEM-1:0] edge_w;
    logic [N_ELEM-1:0]             act_q;
    logic [N_ELEM-1:0]             hit_w;
    logic [N_ELEM-1:0]             next_w;

    nfa_cfg_store #(.N_ELEM(N_ELEM), .SYM_W(SYM_W), .DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_elem (cfg_elem),
        .cfg_word (cfg_word),
        .cfg_data (cfg_data),
        .mask_o   (mask_w),
        .mode_o   (mode_w),
        .rep_o    (rep_w),
        .edge_o   (edge_w)
    );

    nfa_match_unit #(.N_ELEM(N_ELEM), .SYM_W(SYM_W)) u_match (
        .act_i  (act_q),
        .sod_i  (sym_sod),
        .sym_i  (sym),
        .mode_i (mode_w),
        .mask_i (mask_w),
        .hit_o  (hit_w)
    );

    nfa_route #(.N_ELEM(N_ELEM)) u_route (
        .hit_i  (hit_w),
        .edge_i (edge_w),
        .next_o (next_w)
    );

    // Activation register: advances only on a valid symbol
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (sym_valid)
            act_q <= next_w;
    end

    // Registered match, report and valid outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            match_o   <= '0;
            report_o  <= '0;
        end else begin
            out_valid <= sym_valid;
            match_o   <= sym_valid ? hit_w : '0;
            report_o  <= sym_valid ? (hit_w & rep_w) : '0;
        end
    end
endmodule

// File: rtl/nfa_array_chk.sv
// Protocol checker for nfa_array, attached by bind. Watches only ports.
module nfa_array_chk #(
    parameter int N_ELEM = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_valid,
    input logic              out_valid,
    input logic [N_ELEM-1:0] match_o,
    input logic [N_ELEM-1:0] report_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (match_o == '0 && report_o == '0 && !out_valid));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (match_o == '0 && report_o == '0 && !out_valid));

    // R9
    report_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (report_o & ~match_o) == '0);
endmodule

bind nfa_array nfa_array_chk #(.N_ELEM(N_ELEM)) u_nfa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .out_valid (out_valid),
    .match_o   (match_o),
    .report_o  (report_o)
);

// File: tb/test_nfa_array.sv
// Scoreboard bench for nfa_array: the driver queues expected vectors,
// a monitor compares them one edge after each symbol.
module test_nfa_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [4:0]  cfg_elem = '0;
    logic [2:0]  cfg_word = '0;
    logic [31:0] cfg_data = '0;
    logic        sym_valid = 1'b0;
    logic        sym_sod = 1'b0;
    logic [7:0]  sym = '0;
    logic        out_valid;
    logic [31:0] match_o;
    logic [31:0] report_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct { logic [31:0] m; logic [31:0] r; string req; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    nfa_array i_nfa_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_elem(cfg_elem), .cfg_word(cfg_word), .cfg_data(cfg_data),
        .sym_valid(sym_valid), .sym_sod(sym_sod), .sym(sym),
        .out_valid(out_valid), .match_o(match_o), .report_o(report_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] sel, int elem, int word, logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_elem = 5'(elem);
        cfg_word = 3'(word); cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mask1(int elem, int s);
        cfg(2'd0, elem, s >> 5, 32'h1 << (s & 31));
    endtask

    task automatic send(bit sod, byte s, logic [31:0] m, logic [31:0] r, string req);
        exp_t x;
        sym_valid = 1'b1; sym_sod = sod; sym = s;
        x.m = m; x.r = r; x.req = req;
        sb.push_back(x);
        @(negedge clk);
        sym_valid = 1'b0; sym_sod = 1'b0;
    endtask

    // Monitor: pop and compare when a result is presented
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected out_valid", 32'h1, 32'h0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check({x.req, " match"}, match_o, x.m);
                check({x.req, " report"}, report_o, x.r);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        check("R1 out_valid", {31'b0, out_valid}, 32'h0);
        check("R1 match", match_o, 32'h0);
        check("R1 report", report_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: configuration via write port
        mask1(0, 8'h61);                          // e0 'a'
        mask1(1, 8'h62);                          // e1 'b'
        cfg(2'd0, 2, 3, (32'h1 << 1) | (32'h1 << 24)); // e2 'a','x'
        mask1(3, 8'h63);                          // e3 'c'
        mask1(4, 8'h64);                          // e4 'd'
        mask1(5, 8'h71);                          // e5 'q'
        mask1(6, 8'h63);                          // e6 'c', never activated
        cfg(2'd1, 0, 0, 32'd2);                   // e0 all-input
        cfg(2'd1, 1, 0, 32'd4);                   // e1 edge, report
        cfg(2'd1, 2, 0, 32'd5);                   // e2 start-of-data, report
        cfg(2'd1, 5, 0, 32'd2);                   // e5 all-input
        cfg(2'd2, 0, 0, 32'h12);                  // e0 -> e1, e4
        cfg(2'd2, 2, 0, 32'h08);                  // e2 -> e3
        cfg(2'd2, 3, 0, 32'h08);                  // e3 -> e3 self
        cfg(2'd2, 5, 0, 32'h10);                  // e5 -> e4

        send(1, 8'h61, 32'h05, 32'h04, "R6 R7 R12 sod a");
        send(0, 8'h63, 32'h08, 32'h00, "R3 R5 c after sod");
        send(0, 8'h63, 32'h08, 32'h00, "R8 self loop");
        // R10: idle slot gives zero outputs
        sym_valid = 1'b0;
        @(negedge clk);
        check("R10 idle out_valid", {31'b0, out_valid}, 32'h0);
        check("R10 idle match", match_o, 32'h0);
        send(0, 8'h63, 32'h08, 32'h00, "R10 activation held");
        send(0, 8'h62, 32'h00, 32'h00, "R3 inactive b");
        send(0, 8'h61, 32'h01, 32'h00, "R6 R7 a without sod");
        send(0, 8'h62, 32'h02, 32'h02, "R5 R9 chain a b");
        send(0, 8'h71, 32'h20, 32'h00, "R7 all-input q");
        send(0, 8'h64, 32'h10, 32'h00, "R4 second source");
        send(0, 8'h61, 32'h01, 32'h00, "R4 first source a");
        send(1, 8'h62, 32'h00, 32'h00, "R11 sod clears");
        send(1, 8'h78, 32'h04, 32'h04, "R6 R9 sod x");
        send(0, 8'h78, 32'h00, 32'h00, "R6 x without sod");
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb.size()), 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule